// File: doc/BRIEF.md
# Burst Address Counter

This block produces the word address for one port of a burst-capable synchronous memory. At every rising clock edge it picks the address for that cycle's access, using a fixed priority of four choices. A low counter clear forces the address to zero. Otherwise, a low address strobe loads the externally supplied address. Otherwise, a low count enable advances the previous address by one. When none of these controls is active, the previous address is kept.

The chosen address is registered at the edge and appears on the output straight away. The access in that cycle therefore uses the newly computed value. The controls are not gated by chip-select or byte-lane logic, so a deselected port still loads and advances its address. A synchronous active-low system reset clears the register at start-up. The address width is a parameter, and the default of 15 bits covers 32K words.

Top module: `burst_addr_counter`

## Requirements
- R1: When rst_n is low at a rising clock edge, access_addr is 0 after that edge, whatever the other inputs are.
- R2: With rst_n high, clear_n low at a rising edge makes access_addr 0 after that edge, for all four combinations of strobe_n and count_en_n.
- R3: With rst_n and clear_n high, strobe_n low at a rising edge loads ext_addr into access_addr after that edge, whether count_en_n is high or low.
- R4: With rst_n, clear_n, strobe_n and count_en_n all high at a rising edge, access_addr keeps its previous value, and ext_addr has no effect.
- R5: With rst_n, clear_n and strobe_n high and count_en_n low at a rising edge, access_addr becomes its previous value plus one.
- R6: A step from the all-ones address (0x7FFF at the default width) gives 0.
- R7: The width is set by ADDR_W (default 15). With a narrower setting, loads keep only the low ADDR_W bits of the address, and an increment wraps from 2^ADDR_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low system reset |
| ext_addr | input | ADDR_W | Externally supplied address for loading |
| strobe_n | input | 1 | Active-low address strobe (load) |
| count_en_n | input | 1 | Active-low count enable (increment) |
| clear_n | input | 1 | Active-low counter clear to address 0 |
| access_addr | output | ADDR_W | Address used for the current access |

## Verification
Each control combination is applied, with clear low and strobe low each paired with both enable levels. This separates the priority order from a design that lets a lower-priority control win. Hold cycles change ext_addr while strobe is high, which exposes any leak of the external address into a held value. Bursts of increments that start just below the all-ones address check the carry and the wrap. A second instance at a 4-bit width shows that the wrap point and the load truncation follow the parameter. A system reset in the middle of a burst checks that start-up clearing overrides an active increment.

// File: rtl/burst_addr_pkg.sv
// Package: shared types for the burst address counter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package burst_addr_pkg;

    // Address-selection operation chosen for one clock cycle.
    typedef enum logic [1:0] {
        ADDR_OP_KEEP  = 2'd0,
        ADDR_OP_STEP  = 2'd1,
        ADDR_OP_LOAD  = 2'd2,
        ADDR_OP_CLEAR = 2'd3
    } addr_op_e;

endpackage

// File: rtl/burst_addr_decode.sv
// Module: burst_addr_decode
// Turns the three active-low counter controls into a single operation,
// using the fixed priority clear > load > step > keep.
// Assumes the controls are already synchronous to the counter clock.
module burst_addr_decode
    import burst_addr_pkg::*;
(
    input  logic     clear_n,
    input  logic     strobe_n,
    input  logic     count_en_n,
    output addr_op_e op
);

    // Priority selection of the operation for this cycle.
    always_comb begin
        if (!clear_n) begin
            op = ADDR_OP_CLEAR;
        end else if (!strobe_n) begin
            op = ADDR_OP_LOAD;
        end else if (!count_en_n) begin
            op = ADDR_OP_STEP;
        end else begin
            op = ADDR_OP_KEEP;
        end
    end

endmodule

// File: rtl/burst_addr_next.sv
// Module: burst_addr_next
// Computes the next address from the selected operation, the current
// address and the external address. The increment is modulo 2^ADDR_W.
// Assumes op is a valid encoding from burst_addr_decode.
module burst_addr_next
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  addr_op_e          op,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] next_addr
);

    localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;
    localparam logic [ADDR_W-1:0] ONE_ADDR  = ADDR_W'(1);

    logic [ADDR_W-1:0] incr_addr;

    // Modular increment; the carry out of the top bit is dropped.
    always_comb begin
        incr_addr = cur_addr + ONE_ADDR;
    end

    // Select the next address according to the operation.
    always_comb begin
        unique case (op)
            ADDR_OP_CLEAR: next_addr = ZERO_ADDR;
            ADDR_OP_LOAD:  next_addr = ext_addr;
            ADDR_OP_STEP:  next_addr = incr_addr;
            default:       next_addr = cur_addr;
        endcase
    end

endmodule

// File: rtl/burst_addr_reg.sv
// Module: burst_addr_reg
// Address register with a synchronous active-low reset to zero.
// Assumes rst_n is synchronous to clk.
module burst_addr_reg #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Capture the next address, or clear it on system reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/burst_addr_counter.sv
// Module: burst_addr_counter (top)
// Per-port burst address generator. At each rising edge it chooses clear,
// load, step or keep, and registers the result as the address for that
// cycle's access. The controls are deliberately independent of any
// chip-select or byte-lane logic.
// Assumes all inputs are synchronous to clk and ADDR_W >= 1.
module burst_addr_counter
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              count_en_n,
    input  logic              clear_n,
    output logic [ADDR_W-1:0] access_addr
);

    addr_op_e          sel_op;
    logic [ADDR_W-1:0] next_addr;

    burst_addr_decode u_decode (
        .clear_n    (clear_n),
        .strobe_n   (strobe_n),
        .count_en_n (count_en_n),
        .op         (sel_op)
    );

    burst_addr_next #(.ADDR_W(ADDR_W)) u_next (
        .op        (sel_op),
        .cur_addr  (access_addr),
        .ext_addr  (ext_addr),
        .next_addr (next_addr)
    );

    burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_addr),
        .q     (access_addr)
    );

endmodule

// File: rtl/burst_addr_counter_checker.sv
// Module: burst_addr_counter_checker
// Assertion checker bound to burst_addr_counter. It relates the controls
// sampled at one edge to the address seen after that edge.
// Assumes it is attached through the bind statement below.
module burst_addr_counter_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_n,
    input logic              count_en_n,
    input logic              clear_n,
    input logic [ADDR_W-1:0] access_addr
);

    localparam logic [ADDR_W-1:0] ONE_ADDR = ADDR_W'(1);

    logic rst_seen_q;

    // Remember whether reset was applied at the last rising edge.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: after a reset edge the address reads zero (checked mid-cycle).
    always @(negedge clk) begin
        if (rst_seen_q === 1'b1) begin
            assert_reset_zero_R1: assert (access_addr == '0)
                else $error("R1 reset did not clear address");
        end
    end

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> access_addr == '0);

    assert_load_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !strobe_n) |=> access_addr == $past(ext_addr));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && count_en_n) |=> $stable(access_addr));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && !count_en_n)
            |=> access_addr == ADDR_W'($past(access_addr) + ONE_ADDR));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && !count_en_n && (&access_addr))
            |=> access_addr == '0);

endmodule

bind burst_addr_counter burst_addr_counter_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_addr   (ext_addr),
    .strobe_n   (strobe_n),
    .count_en_n (count_en_n),
    .clear_n    (clear_n),
    .access_addr(access_addr)
);

// File: tb/burst_addr_counter_test.sv
// Bench: directed scenarios for burst_addr_counter. A 15-bit instance (uut)
// and a 4-bit instance share the controls; each step compares both against
// a model built from the requirements.
module burst_addr_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ext_addr = '0;
    logic        strobe_n = 1'b1;
    logic        count_en_n = 1'b1;
    logic        clear_n = 1'b1;
    logic [14:0] access_addr;
    logic [3:0]  narrow_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [14:0] exp_w = '0;
    logic [3:0]  exp_n = '0;

    always #5 clk = ~clk;

    burst_addr_counter uut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
        .count_en_n(count_en_n), .clear_n(clear_n), .access_addr(access_addr)
    );

    burst_addr_counter #(.ADDR_W(4)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr[3:0]), .strobe_n(strobe_n),
        .count_en_n(count_en_n), .clear_n(clear_n), .access_addr(narrow_addr)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One clock of control stimulus with the model update and checks of both widths.
    task automatic step(input logic c, input logic s, input logic e,
                        input logic [14:0] x, input string tag);
        @(negedge clk);
        clear_n = c; strobe_n = s; count_en_n = e; ext_addr = x;
        if (!c)      begin exp_w = '0;         exp_n = '0;        end
        else if (!s) begin exp_w = x;          exp_n = x[3:0];    end
        else if (!e) begin exp_w = exp_w + 1'b1; exp_n = exp_n + 1'b1; end
        @(posedge clk);
        #1;
        check(tag, int'(access_addr), int'(exp_w));
        check({tag, "/R7"}, int'(narrow_addr), int'(exp_n));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; clear_n = 1'b1; strobe_n = 1'b0; count_en_n = 1'b0;
        ext_addr = 15'h1ABC;
        @(posedge clk);
        #1;
        check("R1 reset", int'(access_addr), 0);
        check("R1 reset narrow", int'(narrow_addr), 0);
        exp_w = '0; exp_n = '0;
        @(negedge clk);
        rst_n = 1'b1; strobe_n = 1'b1; count_en_n = 1'b1;
    endtask

    task automatic t_load();
        step(1'b1, 1'b0, 1'b1, 15'h1234, "R3 load en high");
        step(1'b1, 1'b0, 1'b0, 15'h5A5B, "R3 load en low");
    endtask

    task automatic t_increment();
        for (int i = 0; i < 5; i++)
            step(1'b1, 1'b1, 1'b0, 15'(16'h7000 + i * 16'h0111), "R5 step");
    endtask

    task automatic t_hold();
        step(1'b1, 1'b1, 1'b1, 15'h0F0F, "R4 hold");
        step(1'b1, 1'b1, 1'b1, 15'h7FFF, "R4 hold");
        step(1'b1, 1'b1, 1'b1, 15'h0000, "R4 hold");
    endtask

    task automatic t_clear();
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, 1'b1, 15'h2345, "R3 preload");
            step(1'b0, k[1], k[0], 15'h6789, "R2 clear");
        end
    endtask

    task automatic t_wrap();
        step(1'b1, 1'b0, 1'b1, 15'h7FFE, "R3 load near top");
        step(1'b1, 1'b1, 1'b0, 15'h0000, "R5 step to top");
        step(1'b1, 1'b1, 1'b0, 15'h0000, "R6 wrap");
        step(1'b1, 1'b0, 1'b1, 15'h03FE, "R3 load narrow top-1");
        step(1'b1, 1'b1, 1'b0, 15'h0000, "R5 step");
        step(1'b1, 1'b1, 1'b0, 15'h0000, "R6 narrow wrap");
    endtask

    task automatic t_reset_mid_burst();
        step(1'b1, 1'b0, 1'b1, 15'h4440, "R3 load");
        step(1'b1, 1'b1, 1'b0, 15'h0000, "R5 step");
        t_reset();
        step(1'b1, 1'b1, 1'b0, 15'h0000, "R5 step after reset");
    endtask

    initial begin
        repeat (200) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_increment();
        t_hold();
        t_clear();
        t_wrap();
        t_reset_mid_burst();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule